// File: doc/BRIEF.md
# Event-Counting Performance Monitor Unit

This block counts clock cycles and hardware events for profiling. It has one cycle counter and a parameterised number of event counters, four by default. All counters are 32 bits wide. Each event counter has an 8-bit code that picks one of 256 event input lines. While counting is enabled, the counter adds one on every clock in which the selected line is high.

Software uses a simple word-addressed register bus. Through it, software can:
- start and stop counting;
- clear the counter groups;
- choose a slow mode for the cycle counter;
- load any counter with a start value, so that an overflow arrives after a chosen period.

When a counter wraps, it sets a sticky overflow flag. A single interrupt line reports every flag whose enable bit is set. Software clears a flag by writing 1 to it.

Address map (word index on `bus_addr`):
- 0: control
- 1: interrupt enable
- 2: overflow flags
- 3: event select
- 4: cycle counter
- 5 to 8: event counters 0 to 3

Top module: `perf_monitor`

## Requirements
- R1: After reset:
  - control reads 0xA5000000;
  - interrupt enable, overflow flags and every counter read 0;
  - event select reads 0xFFFFFFFF;
  - `irq` is low.
- R2: Control keeps only write bits 3:0. On a read:
  - bits 31:24 return the fixed identity code 0xA5;
  - bit 3 returns the slow-mode bit;
  - bit 0 returns the run bit;
  - all other bits read 0.
- R3: No counter changes while the control run bit (bit 0) is 0, unless it is written or cleared.
- R4: Event counter k counts the clocks in which `evt_in[code]` is high. Its code is event select bits 8k+7:8k, so counter 0 uses bits 7:0 and counter 3 uses bits 31:24.
- R5: An event counter whose code is 0xFF never increments, whatever `evt_in` does.
- R6: Every counter wraps from 0xFFFFFFFF to 0. At the wrapping edge it sets its overflow flag:
  - bit 0 for the cycle counter;
  - bit k+1 for event counter k.
- R7: Overflow flags behave as follows:
  - writing 1 to a flag bit clears it;
  - writing 0 leaves the flag unchanged;
  - if a flag is set and cleared at the same edge, the flag ends up set.
- R8: Interrupt-enable bits share the flag bit positions; only bits 4:0 are stored. `irq` is a register. It is high one clock after any flag is high together with its enable bit, and it falls one clock after the last such pair goes away.
- R9: The control reset bits act for one cycle when written as 1, and both read back as 0:
  - bit 1 clears all event counters;
  - bit 2 clears the cycle counter and its prescaler.
- R10: When control bit 3 is 1, the cycle counter increments once every 64 running clocks.
- R11: If a bus write to a counter and an increment of that counter happen in the same cycle, the written value is stored.
- R12: With the run bit set and slow mode off, the cycle counter increments on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word index |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| evt_in | input | 256 | Event input lines, one per event code |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest situations to reach are a flag being set and cleared at the same edge, and a counter being written and incremented at the same edge. Each needs a bus write to land on the exact clock in which a preloaded counter wraps or counts. The stimulus preloads the counter to one step below the event, asserts the selected event line, and raises the bus write in the same half-cycle, so both fall on one edge. Slow mode is checked one clock before and one clock after the 64th running edge. This pins down the prescaler phase after a cycle-counter clear.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int PMON_DATA_W = 32;
  localparam int PMON_ADDR_W = 4;
  localparam int PMON_SEL_W  = 8;

  localparam logic [PMON_ADDR_W-1:0] A_CTL  = 4'd0;
  localparam logic [PMON_ADDR_W-1:0] A_IEN  = 4'd1;
  localparam logic [PMON_ADDR_W-1:0] A_OVF  = 4'd2;
  localparam logic [PMON_ADDR_W-1:0] A_SEL  = 4'd3;
  localparam int                     A_CNT0 = 4;   // cycle counter, then event counters

  localparam logic [PMON_SEL_W-1:0]  SEL_IDLE = '1;

  // Control bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_CLRE = 1;
  localparam int CB_CLRC = 2;
  localparam int CB_SLOW = 3;

  // Read view of control: identity byte, slow bit and run bit only
  function automatic logic [PMON_DATA_W-1:0] ctl_view(input logic [7:0] id,
                                                      input logic slow,
                                                      input logic run);
    logic [PMON_DATA_W-1:0] v;
    v = '0;
    v[31:24]   = id;
    v[CB_SLOW] = slow;
    v[CB_RUN]  = run;
    return v;
  endfunction

  // Pull the code of event counter idx out of the packed select register
  function automatic logic [PMON_SEL_W-1:0] sel_field(input logic [PMON_DATA_W-1:0] v,
                                                      input int idx);
    return v[idx*PMON_SEL_W +: PMON_SEL_W];
  endfunction
endpackage

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  // A wrap is only a real wrap when the increment is the action taken
  assign wrap = inc & ~wr & ~clr & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (wr)  cnt <= wdata;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt == $past(wdata)); // R11
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !clr && !inc) |=> $stable(cnt)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0); // R6
endmodule

// File: rtl/pmon_prescaler.sv
module pmon_prescaler #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  logic [DIV_W-1:0] div_q;

  assign tick = run & (&div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else if (run) div_q <= div_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R10
endmodule

// File: rtl/pmon_flags.sv
module pmon_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr_eff) | set;   // a new overflow beats a clear
      irq   <= |(flags & ien);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set))); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((clr_mask & ~set) != '0)) |=> ((flags & $past(clr_mask & ~set)) == '0)); // R7
  AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((flags & $past(flags)) == $past(flags))); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ien)) |=> irq); // R8
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
  import pmon_pkg::*;
#(
  parameter int         NUM_EVT = 4,
  parameter int         CNT_W   = 32,
  parameter int         PRESC_W = 6,
  parameter logic [7:0] ID_CODE = 8'hA5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PMON_ADDR_W-1:0]      bus_addr,
  input  logic                        bus_wr,
  input  logic [PMON_DATA_W-1:0]      bus_wdata,
  output logic [PMON_DATA_W-1:0]      bus_rdata,
  input  logic [(1<<PMON_SEL_W)-1:0]  evt_in,
  output logic                        irq
);
  localparam int NUM_CNT = NUM_EVT + 1;
  localparam int SEL_TOT = NUM_EVT * PMON_SEL_W;

  // Control and configuration state
  logic               run_q, slow_q;
  logic [NUM_CNT-1:0] ien_q;
  logic [SEL_TOT-1:0] sel_q;

  // Named internal events
  logic               wr_ctl, wr_ien, wr_ovf, wr_sel;
  logic               clr_evt_pulse, clr_cyc_pulse;
  logic               presc_tick;
  logic [NUM_CNT-1:0] cnt_wr, cnt_inc, cnt_clr, cnt_wrap;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0] ovf_flags;

  assign wr_ctl = bus_wr && (bus_addr == A_CTL);
  assign wr_ien = bus_wr && (bus_addr == A_IEN);
  assign wr_ovf = bus_wr && (bus_addr == A_OVF);
  assign wr_sel = bus_wr && (bus_addr == A_SEL);

  assign clr_evt_pulse = wr_ctl && bus_wdata[CB_CLRE];
  assign clr_cyc_pulse = wr_ctl && bus_wdata[CB_CLRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slow_q <= 1'b0;
      ien_q  <= '0;
      sel_q  <= '1;
    end else begin
      if (wr_ctl) begin
        run_q  <= bus_wdata[CB_RUN];
        slow_q <= bus_wdata[CB_SLOW];
      end
      if (wr_ien) ien_q <= bus_wdata[NUM_CNT-1:0];
      if (wr_sel) sel_q <= bus_wdata[SEL_TOT-1:0];
    end
  end

  // Cycle counter prescaler (slow mode)
  pmon_prescaler #(.DIV_W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_cyc_pulse),
    .run   (run_q && slow_q),
    .tick  (presc_tick)
  );

  assign cnt_inc[0] = run_q && (slow_q ? presc_tick : 1'b1);
  assign cnt_clr[0] = clr_cyc_pulse;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
      assign cnt_wr[gi] = bus_wr && (bus_addr == PMON_ADDR_W'(A_CNT0 + gi));

      pmon_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr[gi]),
        .inc   (cnt_inc[gi]),
        .wr    (cnt_wr[gi]),
        .wdata (CNT_W'(bus_wdata)),
        .cnt   (cnt_all[gi]),
        .wrap  (cnt_wrap[gi])
      );
    end

    for (gi = 0; gi < NUM_EVT; gi++) begin : g_evt
      logic [PMON_SEL_W-1:0] code;
      assign code           = sel_field(PMON_DATA_W'(sel_q), gi);
      assign cnt_inc[gi+1]  = run_q && (code != SEL_IDLE) && evt_in[code];
      assign cnt_clr[gi+1]  = clr_evt_pulse;

      AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (code == SEL_IDLE && !cnt_wr[gi+1] && !clr_evt_pulse) |=> $stable(cnt_all[gi+1])); // R5
    end
  endgenerate

  pmon_flags #(.N(NUM_CNT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (cnt_wrap),
    .clr_wr   (wr_ovf),
    .clr_mask (bus_wdata[NUM_CNT-1:0]),
    .ien      (ien_q),
    .flags    (ovf_flags),
    .irq      (irq)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL:   bus_rdata = ctl_view(ID_CODE, slow_q, run_q);
      A_IEN:   bus_rdata = PMON_DATA_W'(ien_q);
      A_OVF:   bus_rdata = PMON_DATA_W'(ovf_flags);
      A_SEL:   bus_rdata = PMON_DATA_W'(sel_q);
      default: begin
        for (int k = 0; k < NUM_CNT; k++)
          if (bus_addr == PMON_ADDR_W'(A_CNT0 + k)) bus_rdata = PMON_DATA_W'(cnt_all[k]);
      end
    endcase
  end

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_ctl && (cnt_wr == '0)) |=> $stable(cnt_all)); // R3
  AST_CYC_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !slow_q && !cnt_wr[0] && !clr_cyc_pulse) |=> cnt_all[0] == $past(cnt_all[0]) + 1'b1); // R12
endmodule

// File: tb/test_perf_monitor.sv
module test_perf_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [255:0] evt_in;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;   // 50 MHz

  perf_monitor i_perf_monitor (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
  );

  localparam logic [3:0] CTL = 0, IEN = 1, OVF = 2, SEL = 3, CYC = 4,
                         E0 = 5, E1 = 6, E2 = 7, E3 = 8;

  typedef struct packed {
    logic [3:0]  a;
    logic        w;
    logic [31:0] d;   // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 1'b1, 32'hFFFF_FFF8, 8'd2},  // R2 write control
    '{4'd0, 1'b0, 32'hA500_0008, 8'd2},  // R2 masked read
    '{4'd0, 1'b1, 32'h0000_0006, 8'd9},  // R9 reset bits
    '{4'd0, 1'b0, 32'hA500_0000, 8'd9},  // R9 read back zero
    '{4'd1, 1'b1, 32'hFFFF_FFFF, 8'd8},  // R8
    '{4'd1, 1'b0, 32'h0000_001F, 8'd8},
    '{4'd1, 1'b1, 32'h0000_0000, 8'd8},
    '{4'd1, 1'b0, 32'h0000_0000, 8'd8},
    '{4'd3, 1'b1, 32'h1234_5678, 8'd4},  // R4
    '{4'd3, 1'b0, 32'h1234_5678, 8'd4},
    '{4'd4, 1'b1, 32'hDEAD_BEEF, 8'd12}, // R12 preload
    '{4'd4, 1'b0, 32'hDEAD_BEEF, 8'd12},
    '{4'd8, 1'b1, 32'h0000_ABCD, 8'd11}, // R11 preload
    '{4'd8, 1'b0, 32'h0000_ABCD, 8'd11},
    '{4'd2, 1'b0, 32'h0000_0000, 8'd7}   // R7
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge; returns at the following negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a; bus_wr = 1'b0;
    #1 v = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(CTL, v); chk("R1 ctl", v, 32'hA500_0000);
    rd(IEN, v); chk("R1 ien", v, 0);
    rd(OVF, v); chk("R1 flags", v, 0);
    rd(SEL, v); chk("R1 select", v, 32'hFFFF_FFFF);
    for (int k = 0; k < 5; k++) begin
      rd(4'(CYC + k), v); chk("R1 counter", v, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);

    // Register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].w) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, v);
        chk($sformatf("R%0d table[%0d]", VEC[i].req, i), v, VEC[i].d);
      end
    end

    // R9 cycle clear leaves event counters; R12 per-clock counting
    wr(CTL, 32'h4);
    rd(CYC, v); chk("R9 cycle cleared", v, 0);
    rd(E3, v);  chk("R9 events untouched", v, 32'h0000_ABCD);
    wr(CYC, 100);
    wr(CTL, 1);
    repeat (9) @(negedge clk);
    wr(CTL, 0);
    rd(CYC, v); chk("R12 ten clocks", v, 110);

    // R9 event clear leaves cycle counter
    wr(CTL, 32'h2);
    rd(E3, v);  chk("R9 events cleared", v, 0);
    rd(CYC, v); chk("R9 cycle untouched", v, 110);

    // R4 field positions: lines 0x0D,0x0C,0x0B,0x0A active 1,2,3,4 clocks
    wr(SEL, 32'h0A0B_0C0D);
    wr(CTL, 1);
    for (int j = 0; j < 4; j++) begin
      evt_in = '0;
      evt_in[8'h0D] = (j < 1);
      evt_in[8'h0C] = (j < 2);
      evt_in[8'h0B] = (j < 3);
      evt_in[8'h0A] = 1'b1;
      @(negedge clk);
    end
    evt_in = '0;
    wr(CTL, 0);
    rd(E0, v); chk("R4 counter0", v, 1);
    rd(E1, v); chk("R4 counter1", v, 2);
    rd(E2, v); chk("R4 counter2", v, 3);
    rd(E3, v); chk("R4 counter3", v, 4);

    // R5 idle code on counter3
    wr(SEL, 32'hFF0B_0C0D);
    wr(CTL, 1);
    evt_in = '1;
    repeat (3) @(negedge clk);
    evt_in = '0;
    wr(CTL, 0);
    rd(E3, v); chk("R5 idle counter held", v, 4);
    rd(E0, v); chk("R5 active counter counted", v, 4);

    // R3 stopped
    rd(CYC, v2);
    evt_in = '1;
    repeat (3) @(negedge clk);
    evt_in = '0;
    rd(E0, v);  chk("R3 event frozen", v, 4);
    rd(CYC, v); chk("R3 cycle frozen", v, v2);

    // R6 / R8 event overflow and interrupt
    wr(SEL, 32'hFFFF_FF05);
    wr(E0, 32'hFFFF_FFFE);
    wr(IEN, 32'h2);
    wr(CTL, 1);
    evt_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    evt_in = '0;
    rd(OVF, v); chk("R6 flag bit1", v, 32'h2);
    chk("R8 irq registered", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R8 irq high", {31'b0, irq}, 1);
    wr(CTL, 0);
    rd(E0, v); chk("R6 wrapped to zero", v, 0);

    // R7 write-one-to-clear
    wr(OVF, 32'h1D);
    rd(OVF, v); chk("R7 zero writes keep flag", v, 32'h2);
    wr(OVF, 32'h2);
    rd(OVF, v); chk("R7 flag cleared", v, 0);
    @(negedge clk);
    chk("R8 irq dropped", {31'b0, irq}, 0);

    // R7 set beats clear on the same edge
    wr(E0, 32'hFFFF_FFFF);
    wr(CTL, 1);
    evt_in[5] = 1'b1; bus_addr = OVF; bus_wr = 1'b1; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0; evt_in = '0;
    wr(CTL, 0);
    rd(OVF, v); chk("R7 set wins", v, 32'h2);
    wr(OVF, 32'h2);

    // R11 write beats increment
    wr(E0, 0);
    wr(CTL, 1);
    evt_in[5] = 1'b1;
    @(negedge clk);
    bus_addr = E0; bus_wr = 1'b1; bus_wdata = 32'h100;
    @(negedge clk);
    bus_wr = 1'b0; evt_in = '0;
    wr(CTL, 0);
    rd(E0, v); chk("R11 write wins", v, 32'h100);

    // R6 cycle counter wrap sets bit0
    wr(IEN, 32'h1);
    wr(CYC, 32'hFFFF_FFFF);
    wr(CTL, 1);
    @(negedge clk);
    wr(CTL, 0);
    rd(CYC, v); chk("R6 cycle wrapped", v, 1);
    rd(OVF, v); chk("R6 flag bit0", v, 32'h1);
    wr(OVF, 32'h1F);

    // R10 slow mode
    wr(CTL, 32'h4);
    wr(CTL, 32'h9);
    repeat (63) @(negedge clk);
    rd(CYC, v); chk("R10 before 64th clock", v, 0);
    @(negedge clk);
    rd(CYC, v); chk("R10 at 64th clock", v, 1);
    wr(CTL, 0);
    rd(CYC, v); chk("R10 no early tick", v, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule